// File: doc/BRIEF.md
# Pad Function Multiplexer Controller

This block holds one configuration word for each of sixteen pads and turns those words into pad controls. For each pad it gives a one-hot choice among five alternate functions, an output enable, a pull-up and a pull-down. The function choice is a 3-bit code whose bits are spread over bit positions 4, 5 and 12 of the word. Each word also holds a second set of enable and pull bits. These replace the normal set while the sleep input is high.

Configuration words are written and read over a simple 32-bit memory-mapped port. A write strobe with an address and data stores the word on the next clock edge. Read data is combinational from the address. The port accepts every access in the cycle it is presented, so there is no back-pressure and no ready signal. Register order does not follow pin order. Two combinational translation ports convert a register index to its GPIO pin number and a pin number back to its index. A per-pad flag shows when the pad is set to its plain GPIO function.

Top module: `padmux_ctrl`

## Requirements
- R1: After reset every configuration word reads 0, every pad selects function A (select bit 0), and all output enables and pulls are low.
- R2: A write with `bus_we` high to byte address 4*(i+1), for i from 0 to 15, stores the data into word i at the next rising clock edge. A read at that address returns word i.
- R3: Only bits 0 to 7 and bit 12 are stored (mask 0x000010FF). All other bits read as 0 and ignore writes.
- R4: A write to byte address 0, to an address above 64, or to an address that is not a multiple of 4 changes no word. A read at such an address returns 0.
- R5: The function code {bit12, bit5, bit4} drives the pad's 5-bit select one-hot: 000 gives A (select bit 0), 001 gives B (bit 1), 010 gives C (bit 2), 011 gives D (bit 3), 100 gives E (bit 4).
- R6: Any other code (101, 110, 111) selects no function, and it forces that pad's output enable low. The pulls still apply.
- R7: While `sleep_i` is low, a pad's output enable comes from bit 0, its pull-down from bit 6 and its pull-up from bit 7.
- R8: While `sleep_i` is high, a pad's output enable comes from bit 1, its pull-down from bit 2 and its pull-up from bit 3.
- R9: When the active pull-up and pull-down bits are both set, only the pull-up is driven.
- R10: `pad_is_gpio[i]` is high when word i holds code D (011) for i from 0 to 11, or code A (000) for i from 12 to 15.
- R11: `map_pin_o` gives the GPIO pin for register index `map_idx_i` using the table 12,13,14,15,3,1,6,7,8,9,10,11,0,2,4,5 for indices 0 to 15.
- R12: `map_idx_o` gives the register index whose pin is `map_pin_i`. This is the exact inverse of the R11 table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, accepted in the same cycle |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| sleep_i | input | 1 | Selects the sleep set of enable and pull bits |
| pad_fsel | output | NUM_PADS*5 | One-hot function select, 5 bits per pad, pad i at bits 5i+4..5i |
| pad_oe | output | NUM_PADS | Output enable per pad |
| pad_pu | output | NUM_PADS | Pull-up per pad |
| pad_pd | output | NUM_PADS | Pull-down per pad |
| pad_is_gpio | output | NUM_PADS | Pad is set to its plain GPIO function |
| map_idx_i | input | 4 | Register index to translate |
| map_pin_o | output | 4 | GPIO pin for `map_idx_i` |
| map_pin_i | input | 4 | GPIO pin to translate |
| map_idx_o | output | 4 | Register index for `map_pin_i` |

## Verification
The assertions check these rules on every cycle:
- each pad's select stays one-hot or empty;
- an empty select never comes with an enabled output;
- pull-up and pull-down are never both driven;
- the enable and pull source follows `sleep_i` for every valid code;
- a write to a pad's address lands, masked, in that word;
- a misaligned write leaves every word unchanged;
- the two translation ports agree whenever their pin values match.

Only the bench's scenarios can show some behaviours:
- the reset state;
- the exact table values;
- which register index counts as GPIO with which code;
- read-back of stray addresses;
- that writes to out-of-range aligned addresses leave the whole bank untouched.

// File: rtl/padmux_pkg.sv
`timescale 1ns/1ps
package padmux_pkg;

  localparam int NUM_FUNC = 5;

  // Stored bits of a configuration word
  localparam logic [31:0] CFG_WMASK = 32'h0000_10FF;

  // Bit positions inside a configuration word
  localparam int B_OE      = 0;
  localparam int B_OE_SLP  = 1;
  localparam int B_PD_SLP  = 2;
  localparam int B_PU_SLP  = 3;
  localparam int B_FC0     = 4;
  localparam int B_FC1     = 5;
  localparam int B_PD      = 6;
  localparam int B_PU      = 7;
  localparam int B_FC2     = 12;

  // Indices below this use code D as plain GPIO, the rest code A
  localparam int GPIO_LOW_BANK = 12;

  typedef enum logic [2:0] {
    FN_A = 3'b000,
    FN_B = 3'b001,
    FN_C = 3'b010,
    FN_D = 3'b011,
    FN_E = 3'b100
  } fn_code_e;

  // Register index to GPIO pin number
  function automatic logic [3:0] idx_to_pin(input logic [3:0] idx);
    case (idx)
      4'd0:  idx_to_pin = 4'd12;
      4'd1:  idx_to_pin = 4'd13;
      4'd2:  idx_to_pin = 4'd14;
      4'd3:  idx_to_pin = 4'd15;
      4'd4:  idx_to_pin = 4'd3;
      4'd5:  idx_to_pin = 4'd1;
      4'd6:  idx_to_pin = 4'd6;
      4'd7:  idx_to_pin = 4'd7;
      4'd8:  idx_to_pin = 4'd8;
      4'd9:  idx_to_pin = 4'd9;
      4'd10: idx_to_pin = 4'd10;
      4'd11: idx_to_pin = 4'd11;
      4'd12: idx_to_pin = 4'd0;
      4'd13: idx_to_pin = 4'd2;
      4'd14: idx_to_pin = 4'd4;
      default: idx_to_pin = 4'd5;
    endcase
  endfunction

endpackage

// File: rtl/padmux_regfile.sv
`timescale 1ns/1ps
module padmux_regfile
  import padmux_pkg::*;
#(
  parameter int NUM_PADS = 16,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_we,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic [NUM_PADS*DATA_W-1:0] cfg_o
);

  localparam int IDX_W  = $clog2(NUM_PADS);
  localparam int SLOT_W = ADDR_W - 2;
  localparam logic [DATA_W-1:0] WMASK = DATA_W'(CFG_WMASK);

  logic [SLOT_W-1:0] slot;
  logic [IDX_W-1:0]  idx;
  logic              hit;
  logic [DATA_W-1:0] cfg_q [NUM_PADS];

  // Word i lives at word slot i+1; slot 0 is not a register
  assign slot = bus_addr[ADDR_W-1:2];
  assign hit  = (bus_addr[1:0] == 2'b00) && (slot != '0) && (int'(slot) <= NUM_PADS);
  assign idx  = IDX_W'(slot - SLOT_W'(1));

  for (genvar g = 0; g < NUM_PADS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[g] <= '0;
      end else if (bus_we && hit && (idx == IDX_W'(g))) begin
        cfg_q[g] <= bus_wdata & WMASK;
      end
    end
    assign cfg_o[g*DATA_W +: DATA_W] = cfg_q[g];
  end

  assign bus_rdata = hit ? cfg_q[idx] : '0;

endmodule

// File: rtl/padmux_pad_decode.sv
`timescale 1ns/1ps
module padmux_pad_decode
  import padmux_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter logic [2:0]  GPIO_CODE = FN_D
) (
  input  logic [DATA_W-1:0]   cfg_i,
  input  logic                sleep_i,
  output logic [NUM_FUNC-1:0] fsel_o,
  output logic                oe_o,
  output logic                pu_o,
  output logic                pd_o,
  output logic                is_gpio_o
);

  logic [2:0] code;
  logic       oe_raw;
  logic       pd_raw;
  logic       unused_cfg;

  assign code = {cfg_i[B_FC2], cfg_i[B_FC1], cfg_i[B_FC0]};

  always_comb begin
    case (code)
      FN_A:    fsel_o = NUM_FUNC'(5'b00001);
      FN_B:    fsel_o = NUM_FUNC'(5'b00010);
      FN_C:    fsel_o = NUM_FUNC'(5'b00100);
      FN_D:    fsel_o = NUM_FUNC'(5'b01000);
      FN_E:    fsel_o = NUM_FUNC'(5'b10000);
      default: fsel_o = '0;
    endcase
  end

  assign oe_raw    = sleep_i ? cfg_i[B_OE_SLP] : cfg_i[B_OE];
  assign pu_o      = sleep_i ? cfg_i[B_PU_SLP] : cfg_i[B_PU];
  assign pd_raw    = sleep_i ? cfg_i[B_PD_SLP] : cfg_i[B_PD];
  assign pd_o      = pd_raw & ~pu_o;
  assign oe_o      = oe_raw & (|fsel_o);
  assign is_gpio_o = (code == GPIO_CODE);

  assign unused_cfg = ^{cfg_i[DATA_W-1:B_FC2+1], cfg_i[B_FC2-1:B_PU+1]};

endmodule

// File: rtl/padmux_xlat.sv
`timescale 1ns/1ps
module padmux_xlat
  import padmux_pkg::*;
#(
  parameter int NUM_PADS = 16
) (
  input  logic [$clog2(NUM_PADS)-1:0] idx_i,
  output logic [$clog2(NUM_PADS)-1:0] pin_o,
  input  logic [$clog2(NUM_PADS)-1:0] pin_i,
  output logic [$clog2(NUM_PADS)-1:0] idx_o
);

  localparam int IDX_W = $clog2(NUM_PADS);

  assign pin_o = IDX_W'(idx_to_pin(4'(idx_i)));

  // Inverse found by search over the forward table
  always_comb begin
    idx_o = '0;
    for (int k = 0; k < NUM_PADS; k++) begin
      if (IDX_W'(idx_to_pin(4'(k))) == pin_i) idx_o = IDX_W'(k);
    end
  end

endmodule

// File: rtl/padmux_ctrl.sv
`timescale 1ns/1ps
module padmux_ctrl
  import padmux_pkg::*;
#(
  parameter int NUM_PADS = 16,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_we,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [DATA_W-1:0]            bus_wdata,
  output logic [DATA_W-1:0]            bus_rdata,
  input  logic                         sleep_i,
  output logic [NUM_PADS*NUM_FUNC-1:0] pad_fsel,
  output logic [NUM_PADS-1:0]          pad_oe,
  output logic [NUM_PADS-1:0]          pad_pu,
  output logic [NUM_PADS-1:0]          pad_pd,
  output logic [NUM_PADS-1:0]          pad_is_gpio,
  input  logic [$clog2(NUM_PADS)-1:0]  map_idx_i,
  output logic [$clog2(NUM_PADS)-1:0]  map_pin_o,
  input  logic [$clog2(NUM_PADS)-1:0]  map_pin_i,
  output logic [$clog2(NUM_PADS)-1:0]  map_idx_o
);

  logic [NUM_PADS*DATA_W-1:0] cfg_flat;

  padmux_regfile #(
    .NUM_PADS (NUM_PADS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cfg_o     (cfg_flat)
  );

  for (genvar g = 0; g < NUM_PADS; g++) begin : g_pad
    localparam logic [2:0] GCODE = (g < GPIO_LOW_BANK) ? FN_D : FN_A;
    padmux_pad_decode #(
      .DATA_W    (DATA_W),
      .GPIO_CODE (GCODE)
    ) u_dec (
      .cfg_i     (cfg_flat[g*DATA_W +: DATA_W]),
      .sleep_i   (sleep_i),
      .fsel_o    (pad_fsel[g*NUM_FUNC +: NUM_FUNC]),
      .oe_o      (pad_oe[g]),
      .pu_o      (pad_pu[g]),
      .pd_o      (pad_pd[g]),
      .is_gpio_o (pad_is_gpio[g])
    );
  end

  padmux_xlat #(
    .NUM_PADS (NUM_PADS)
  ) u_xlat (
    .idx_i (map_idx_i),
    .pin_o (map_pin_o),
    .pin_i (map_pin_i),
    .idx_o (map_idx_o)
  );

endmodule

// File: rtl/padmux_ctrl_chk.sv
`timescale 1ns/1ps
module padmux_ctrl_chk
  import padmux_pkg::*;
#(
  parameter int NUM_PADS = 16,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         bus_we,
  input logic [ADDR_W-1:0]            bus_addr,
  input logic [DATA_W-1:0]            bus_wdata,
  input logic                         sleep_i,
  input logic [NUM_PADS*NUM_FUNC-1:0] pad_fsel,
  input logic [NUM_PADS-1:0]          pad_oe,
  input logic [NUM_PADS-1:0]          pad_pu,
  input logic [NUM_PADS-1:0]          pad_pd,
  input logic [NUM_PADS*DATA_W-1:0]   cfg_flat,
  input logic [$clog2(NUM_PADS)-1:0]  map_idx_i,
  input logic [$clog2(NUM_PADS)-1:0]  map_pin_o,
  input logic [$clog2(NUM_PADS)-1:0]  map_pin_i,
  input logic [$clog2(NUM_PADS)-1:0]  map_idx_o
);

  localparam logic [DATA_W-1:0] WMASK = DATA_W'(CFG_WMASK);

  p_misaligned_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_addr[1:0] != 2'b00)) |=> $stable(cfg_flat));

  p_map_inverse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (map_pin_i == map_pin_o) |-> (map_idx_o == map_idx_i));

  for (genvar k = 0; k < NUM_PADS; k++) begin : g_chk
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && (bus_addr == ADDR_W'(4*(k+1)))) |=>
        (cfg_flat[k*DATA_W +: DATA_W] == ($past(bus_wdata) & WMASK)));

    p_sel_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pad_fsel[k*NUM_FUNC +: NUM_FUNC]));

    p_bad_code_oe_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_fsel[k*NUM_FUNC +: NUM_FUNC] == '0) |-> !pad_oe[k]);

    p_awake_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep_i && (pad_fsel[k*NUM_FUNC +: NUM_FUNC] != '0)) |->
        ((pad_oe[k] == cfg_flat[k*DATA_W + B_OE]) && (pad_pu[k] == cfg_flat[k*DATA_W + B_PU])));

    p_sleep_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_i && (pad_fsel[k*NUM_FUNC +: NUM_FUNC] != '0)) |->
        ((pad_oe[k] == cfg_flat[k*DATA_W + B_OE_SLP]) && (pad_pu[k] == cfg_flat[k*DATA_W + B_PU_SLP])));

    p_pull_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(pad_pu[k] && pad_pd[k]));
  end

endmodule

bind padmux_ctrl padmux_ctrl_chk #(
  .NUM_PADS (NUM_PADS),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .sleep_i   (sleep_i),
  .pad_fsel  (pad_fsel),
  .pad_oe    (pad_oe),
  .pad_pu    (pad_pu),
  .pad_pd    (pad_pd),
  .cfg_flat  (cfg_flat),
  .map_idx_i (map_idx_i),
  .map_pin_o (map_pin_o),
  .map_pin_i (map_pin_i),
  .map_idx_o (map_idx_o)
);

// File: tb/test_padmux_ctrl.sv
`timescale 1ns/1ps
module test_padmux_ctrl;

  localparam int NP = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sleep_i = 1'b0;
  logic [NP*5-1:0] pad_fsel;
  logic [NP-1:0] pad_oe, pad_pu, pad_pd, pad_is_gpio;
  logic [3:0]  map_idx_i = '0, map_pin_o, map_pin_i = '0, map_idx_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] model [NP];

  always #2.5 clk = ~clk;

  padmux_ctrl i_padmux_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sleep_i(sleep_i),
    .pad_fsel(pad_fsel), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .pad_is_gpio(pad_is_gpio), .map_idx_i(map_idx_i), .map_pin_o(map_pin_o),
    .map_pin_i(map_pin_i), .map_idx_o(map_idx_o)
  );

  function automatic logic [4:0] e_sel(input logic [31:0] c);
    case ({c[12], c[5], c[4]})
      3'b000: e_sel = 5'b00001;
      3'b001: e_sel = 5'b00010;
      3'b010: e_sel = 5'b00100;
      3'b011: e_sel = 5'b01000;
      3'b100: e_sel = 5'b10000;
      default: e_sel = 5'b00000;
    endcase
  endfunction

  function automatic logic e_pu(input logic [31:0] c, input logic s);
    e_pu = s ? c[3] : c[7];
  endfunction

  function automatic logic e_pd(input logic [31:0] c, input logic s);
    e_pd = (s ? c[2] : c[6]) & ~e_pu(c, s);
  endfunction

  function automatic logic e_oe(input logic [31:0] c, input logic s);
    e_oe = (s ? c[1] : c[0]) & (e_sel(c) != 5'b0);
  endfunction

  function automatic logic [3:0] e_pin(input int i);
    int tbl [16] = '{12, 13, 14, 15, 3, 1, 6, 7, 8, 9, 10, 11, 0, 2, 4, 5};
    e_pin = 4'(tbl[i]);
  endfunction

  function automatic logic e_gpio(input logic [31:0] c, input int i);
    e_gpio = (i < 12) ? ({c[12], c[5], c[4]} == 3'b011) : ({c[12], c[5], c[4]} == 3'b000);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    #1;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic pads_chk();
    for (int i = 0; i < NP; i++) begin
      chk("R5/R6 fsel", 32'(pad_fsel[i*5 +: 5]), 32'(e_sel(model[i])));
      chk(sleep_i ? "R8/R6 oe" : "R7/R6 oe", 32'(pad_oe[i]), 32'(e_oe(model[i], sleep_i)));
      chk(sleep_i ? "R8 pu" : "R7 pu", 32'(pad_pu[i]), 32'(e_pu(model[i], sleep_i)));
      chk("R9 pd", 32'(pad_pd[i]), 32'(e_pd(model[i], sleep_i)));
      chk("R10 gpio", 32'(pad_is_gpio[i]), 32'(e_gpio(model[i], i)));
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NP; i++) model[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R1 reset state
    for (int i = 0; i < NP; i++) rd_chk("R1 reset read", 8'(4*(i+1)), 32'h0);
    for (int i = 0; i < NP; i++) begin
      chk("R1 reset fsel", 32'(pad_fsel[i*5 +: 5]), 32'h1);
      chk("R1 reset oe/pu/pd", {29'b0, pad_oe[i], pad_pu[i], pad_pd[i]}, 32'h0);
    end
    pads_chk();

    // R11 / R12 translation tables
    for (int i = 0; i < NP; i++) begin
      map_idx_i = 4'(i);
      map_pin_i = e_pin(i);
      #1;
      chk("R11 idx->pin", 32'(map_pin_o), 32'(e_pin(i)));
      chk("R12 pin->idx", 32'(map_idx_o), 32'(i));
    end

    // R2 / R3 masking
    wr(8'd4, 32'hFFFF_FFFF); model[0] = 32'h0000_10FF;
    rd_chk("R3 mask", 8'd4, 32'h0000_10FF);
    wr(8'd64, 32'hA5A5_5A3B); model[15] = 32'hA5A5_5A3B & 32'h10FF;
    rd_chk("R2 last word", 8'd64, model[15]);
    pads_chk();

    // R4 stray addresses
    wr(8'd0, 32'hFFFF_FFFF);
    wr(8'd68, 32'hFFFF_FFFF);
    wr(8'd6, 32'hFFFF_FFFF);
    wr(8'd255, 32'hFFFF_FFFF);
    rd_chk("R4 read addr0", 8'd0, 32'h0);
    rd_chk("R4 read addr68", 8'd68, 32'h0);
    rd_chk("R4 read unaligned", 8'd5, 32'h0);
    for (int i = 0; i < NP; i++) rd_chk("R4 bank untouched", 8'(4*(i+1)), model[i]);

    // R6 undefined code with oe set
    wr(8'd8, 32'h0000_1011); model[1] = 32'h0000_1011;
    chk("R6 no select", 32'(pad_fsel[5 +: 5]), 32'h0);
    chk("R6 oe forced off", 32'(pad_oe[1]), 32'h0);

    // R9 both pulls, awake then sleep
    wr(8'd12, 32'h0000_00CD); model[2] = 32'h0000_00CD;
    chk("R9 awake pu wins", {30'b0, pad_pu[2], pad_pd[2]}, 32'h2);
    sleep_i = 1'b1; #1;
    chk("R8 sleep oe", 32'(pad_oe[2]), 32'h0);
    chk("R9 sleep pu wins", {30'b0, pad_pu[2], pad_pd[2]}, 32'h2);
    sleep_i = 1'b0; #1;

    // R10 gpio codes on both banks
    wr(8'd16, 32'h0000_0030); model[3] = 32'h30;
    wr(8'd56, 32'h0000_0030); model[13] = 32'h30;
    chk("R10 idx3 code D", 32'(pad_is_gpio[3]), 32'h1);
    chk("R10 idx13 code D", 32'(pad_is_gpio[13]), 32'h0);
    chk("R10 idx14 code A", 32'(pad_is_gpio[14]), 32'h1);
    pads_chk();

    // Random mix
    for (int it = 0; it < 300; it++) begin
      int idx;
      logic [31:0] d;
      logic [2:0] cd;
      idx = int'($urandom_range(0, NP-1));
      d = $urandom();
      if ($urandom_range(0, 3) != 0) begin
        cd = 3'($urandom_range(0, 4));
        d[4] = cd[0]; d[5] = cd[1]; d[12] = cd[2];
      end
      wr(8'(4*(idx+1)), d);
      model[idx] = d & 32'h10FF;
      sleep_i = 1'($urandom_range(0, 1));
      #1;
      rd_chk("R2 random readback", 8'(4*(idx+1)), model[idx]);
      pads_chk();
    end

    finish_run();
  end

endmodule